// File: doc/BRIEF.md
# Card Clock Divider

This block derives the clock that drives a memory-card bus from the block's master clock. It takes the contents of one clock-control register as a parallel word, registers it once, and from it produces the card clock, two single-cycle strobes that mark the rising and falling card-clock edges for the command and data shift logic, a decoded bus-width code, a registered copy of the hardware flow-control enable, and a flag that asks the output stage to launch data on the falling edge.

A build-time parameter picks the divide law. With `ALT_LAW = 0` the card clock period is 2·(div+1) master cycles with equal high and low phases. With `ALT_LAW = 1` the period is div+2 master cycles, and for odd ratios the high phase is one cycle shorter than the low phase. A bypass bit hands the master clock straight to the card pins. A divider value loaded mid-period waits for the next rising card-clock edge, so the card never sees a shortened pulse. With the 8-bit divider, the slowest card clock is mclk/512.

Control word layout (bit positions for the default `DIV_W = 8`): bits [7:0] divider value, bit 8 enable, bit 9 bypass, bit 10 falling-edge launch, bit 11 flow-control enable, bit 12 four-line bus, bit 13 eight-line bus.

Top module: `cclk_gen`

## Requirements
- R1: With `ALT_LAW = 0`, enable (bit 8) set and bypass (bit 9) clear, `cclk_o` is high for div+1 and low for div+1 master cycles, where div is bits [7:0].
- R2: With `ALT_LAW = 1`, the card clock period is div+2 master cycles; the high phase lasts floor((div+2)/2) cycles and the low phase the remaining cycles.
- R3: A divider value of 255 gives a 512-cycle period under `ALT_LAW = 0` (256 high, 256 low) and a 257-cycle period under `ALT_LAW = 1` (128 high, 129 low).
- R4: While the enable bit is clear, `cclk_o` stays low and neither strobe fires, from the second master edge after the clear; after enable is set, the first rising card-clock edge comes on the second master edge after the word is presented.
- R5: With enable and bypass set, `cclk_o` follows the master clock and both `rise_tick_o` and `fall_tick_o` are high in every cycle.
- R6: `neg_launch_o` is 1 only when `ALT_LAW = 1` and both bypass (bit 9) and falling-edge launch (bit 10) are set; otherwise 0.
- R7: `bus_width_o` is 0 for one data line, 1 for four lines (bit 12) and 2 for eight lines (bit 13); when both bits are set, eight lines win.
- R8: A divider value written during a card-clock period leaves that period's high and low lengths unchanged; it applies from the next rising card-clock edge.
- R9: In divided mode, `rise_tick_o` is high for exactly one cycle per period, the first cycle of the high phase, and `fall_tick_o` for exactly one cycle, the first cycle of the low phase.
- R10: `flow_en_o` equals bit 11 of the control word, one master edge after the word is presented.
- R11: During reset, `cclk_o`, both strobes, `neg_launch_o`, `flow_en_o` and `bus_width_o` are all 0, whatever the control word holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 14 | Clock-control register contents (layout above) |
| cclk_o | output | 1 | Card bus clock |
| rise_tick_o | output | 1 | Strobe in the first cycle after a rising card-clock edge |
| fall_tick_o | output | 1 | Strobe in the first cycle after a falling card-clock edge |
| neg_launch_o | output | 1 | Request to launch output data on the falling edge |
| flow_en_o | output | 1 | Registered hardware flow-control enable |
| bus_width_o | output | 2 | Data bus width code: 0 = 1 line, 1 = 4 lines, 2 = 8 lines |

## Verification
The hardest case to reach from the ports is a divider change landing inside a running card-clock period, because the boundary rule is only visible if the write falls strictly between two rising edges. The bench waits on `rise_tick_o`, presents a new divider value in that same cycle, and then times the current period and the following one separately. The expected lengths are the old value for the first and the new value for the second. The odd-ratio asymmetry of the alternate law and the 255 extremes are reached from a vector table that runs both law variants side by side.

// File: rtl/cclk_pkg.sv
// Shared definitions for the card clock divider.
// Field offsets of the control word are given relative to the divider
// width, so the word layout tracks DIV_W.
package cclk_pkg;

    localparam int OFS_EN     = 0;
    localparam int OFS_BYPASS = 1;
    localparam int OFS_NEG    = 2;
    localparam int OFS_FLOW   = 3;
    localparam int OFS_W4     = 4;
    localparam int OFS_W8     = 5;
    localparam int FLAG_BITS  = 6;

    typedef enum logic [1:0] {
        BW_ONE   = 2'd0,
        BW_FOUR  = 2'd1,
        BW_EIGHT = 2'd2
    } bus_width_e;

endpackage

// File: rtl/cclk_cfg_reg.sv
// Control-word capture.
// Registers the clock-control word once and splits it into fields.
// Assumes the word is stable around the master edge (same clock domain).
module cclk_cfg_reg
    import cclk_pkg::*;
#(
    parameter int DIV_W = 8,
    localparam int CTRL_W = DIV_W + FLAG_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic [DIV_W-1:0]  div_q,
    output logic              en_q,
    output logic              bypass_q,
    output logic              neg_q,
    output logic              flow_q,
    output logic              w4_q,
    output logic              w8_q
);

    logic [CTRL_W-1:0] word_q;

    // capture the control word; reset clears every field
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= ctrl_word;
    end

    // field split
    always_comb begin
        div_q    = word_q[DIV_W-1:0];
        en_q     = word_q[DIV_W + OFS_EN];
        bypass_q = word_q[DIV_W + OFS_BYPASS];
        neg_q    = word_q[DIV_W + OFS_NEG];
        flow_q   = word_q[DIV_W + OFS_FLOW];
        w4_q     = word_q[DIV_W + OFS_W4];
        w8_q     = word_q[DIV_W + OFS_W8];
    end

endmodule

// File: rtl/cclk_bus_width.sv
// Bus-width decode.
// Turns the two line-count bits into a width code; eight lines take
// priority when both bits are set.
module cclk_bus_width
    import cclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       w4,
    input  logic       w8,
    output logic [1:0] code
);

    bus_width_e width;

    // priority decode of the width bits
    always_comb begin
        if (w8)      width = BW_EIGHT;
        else if (w4) width = BW_FOUR;
        else         width = BW_ONE;
        code = width;
    end

    // R7
    bw_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code != 2'd3);

endmodule

// File: rtl/cclk_div_core.sv
// Divided card-clock generator.
// Counts master cycles through a high and a low phase. Phase lengths are
// latched at each rising card-clock edge, so a new divider value waits for
// the next period. A low 'go' stops the clock low and re-arms the core so
// the next start rises on the first edge.
module cclk_div_core #(
    parameter int DIV_W   = 8,
    parameter bit ALT_LAW = 1'b0,
    localparam int CNT_W  = DIV_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [DIV_W-1:0] div,
    output logic             cclk_q,
    output logic             rise_q,
    output logic             fall_q
);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hi_last_q;
    logic [CNT_W-1:0] lo_last_q;
    logic [CNT_W-1:0] hi_last_d;
    logic [CNT_W-1:0] lo_last_d;

    // phase lengths (minus one) for the selected divide law
    generate
        if (ALT_LAW) begin : g_alt
            logic [CNT_W-1:0] ratio;
            logic [CNT_W-1:0] hi_len;
            always_comb begin
                ratio     = {1'b0, div} + CNT_W'(2);
                hi_len    = ratio >> 1;
                hi_last_d = hi_len - CNT_W'(1);
                lo_last_d = ratio - hi_len - CNT_W'(1);
            end
        end else begin : g_std
            always_comb begin
                hi_last_d = {1'b0, div};
                lo_last_d = {1'b0, div};
            end
        end
    endgenerate

    // phase sequencing, length latch and edge strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            cclk_q    <= 1'b0;
            cnt_q     <= '0;
            hi_last_q <= '0;
            lo_last_q <= '0;
            rise_q    <= 1'b0;
            fall_q    <= 1'b0;
        end else if (!go) begin
            run_q  <= 1'b0;
            cclk_q <= 1'b0;
            cnt_q  <= '0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
            if (!run_q || (!cclk_q && cnt_q == lo_last_q)) begin
                run_q     <= 1'b1;
                cclk_q    <= 1'b1;
                cnt_q     <= '0;
                hi_last_q <= hi_last_d;
                lo_last_q <= lo_last_d;
                rise_q    <= 1'b1;
            end else if (cclk_q && cnt_q == hi_last_q) begin
                cclk_q <= 1'b0;
                cnt_q  <= '0;
                fall_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // R9
    rise_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_q |-> (cclk_q && !$past(cclk_q)));

    // R9
    fall_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_q |-> (!cclk_q && $past(cclk_q)));

    // R4
    stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (!cclk_q && !rise_q && !fall_q));

    // R8
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_q |-> ($stable(hi_last_q) && $stable(lo_last_q)));

    // R1
    phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cclk_q ? (cnt_q <= hi_last_q) : (cnt_q <= lo_last_q)));

endmodule

// File: rtl/cclk_gen.sv
// Card clock divider, top level.
// Registers the control word, runs the divider core, and selects the
// master clock itself when bypass is set. Assumes the control word comes
// from the master-clock domain.
module cclk_gen
    import cclk_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter bit ALT_LAW = 1'b0,
    localparam int CTRL_W = DIV_W + FLAG_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic              cclk_o,
    output logic              rise_tick_o,
    output logic              fall_tick_o,
    output logic              neg_launch_o,
    output logic              flow_en_o,
    output logic [1:0]        bus_width_o
);

    logic [DIV_W-1:0] div_q;
    logic             en_q, bypass_q, neg_q, flow_q, w4_q, w8_q;
    logic             core_cclk, core_rise, core_fall;
    logic             pass_on;

    cclk_cfg_reg #(.DIV_W(DIV_W)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_word(ctrl_word),
        .div_q    (div_q),
        .en_q     (en_q),
        .bypass_q (bypass_q),
        .neg_q    (neg_q),
        .flow_q   (flow_q),
        .w4_q     (w4_q),
        .w8_q     (w8_q)
    );

    cclk_div_core #(.DIV_W(DIV_W), .ALT_LAW(ALT_LAW)) core_i (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (en_q && !bypass_q),
        .div   (div_q),
        .cclk_q(core_cclk),
        .rise_q(core_rise),
        .fall_q(core_fall)
    );

    cclk_bus_width width_i (
        .clk  (clk),
        .rst_n(rst_n),
        .w4   (w4_q),
        .w8   (w8_q),
        .code (bus_width_o)
    );

    // output selection between divided clock and master-clock bypass
    always_comb begin
        pass_on      = en_q && bypass_q;
        cclk_o       = pass_on ? clk : core_cclk;
        rise_tick_o  = pass_on | core_rise;
        fall_tick_o  = pass_on | core_fall;
        neg_launch_o = ALT_LAW && bypass_q && neg_q;
        flow_en_o    = flow_q;
    end

    // R5
    bypass_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && bypass_q) |-> (rise_tick_o && fall_tick_o));

endmodule

// File: tb/cclk_gen_tb.sv
// Bench for the card clock divider: one instance per divide law.
module cclk_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;
    localparam int CTRL_W     = DIV_W + 6;
    localparam int WATCHDOG   = 150000;

    // vector: {law[3:0], div[7:0], high[11:0], low[11:0]}
    localparam int NVEC = 8;
    localparam logic [35:0] VEC [NVEC] = '{
        {4'd0, 8'd0,   12'd1,   12'd1},
        {4'd0, 8'd3,   12'd4,   12'd4},
        {4'd0, 8'd255, 12'd256, 12'd256},
        {4'd1, 8'd0,   12'd1,   12'd1},
        {4'd1, 8'd1,   12'd1,   12'd2},
        {4'd1, 8'd4,   12'd3,   12'd3},
        {4'd1, 8'd7,   12'd4,   12'd5},
        {4'd1, 8'd255, 12'd128, 12'd129}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CTRL_W-1:0] ctrl_word = '0;
    logic              sel = 1'b0;

    logic       c0, r0, f0, n0, fl0;
    logic       c1, r1, f1, n1, fl1;
    logic [1:0] bw0, bw1;
    logic       s_cclk, s_rise, s_fall;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cclk_gen #(.DIV_W(DIV_W), .ALT_LAW(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
        .cclk_o(c0), .rise_tick_o(r0), .fall_tick_o(f0),
        .neg_launch_o(n0), .flow_en_o(fl0), .bus_width_o(bw0));

    cclk_gen #(.DIV_W(DIV_W), .ALT_LAW(1'b1)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
        .cclk_o(c1), .rise_tick_o(r1), .fall_tick_o(f1),
        .neg_launch_o(n1), .flow_en_o(fl1), .bus_width_o(bw1));

    assign s_cclk = sel ? c1 : c0;
    assign s_rise = sel ? r1 : r0;
    assign s_fall = sel ? f1 : f0;

    function automatic logic [CTRL_W-1:0] mk(input logic [7:0] div, input logic en,
            input logic byp, input logic neg, input logic flow,
            input logic w4, input logic w8);
        return {w8, w4, flow, neg, byp, en, div};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_rise();
        do @(negedge clk); while (!s_rise);
    endtask

    // starts at a negedge where a rise strobe was just seen
    task automatic measure(output int hi, output int lo, output int rt, output int ft);
        hi = 0; lo = 0; rt = 0; ft = 0;
        while (s_cclk) begin
            hi++; rt += int'(s_rise); ft += int'(s_fall);
            @(negedge clk);
        end
        while (!s_cclk) begin
            lo++; rt += int'(s_rise); ft += int'(s_fall);
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int hi, lo, rt, ft;
        string tag;

        // R11: reset wins over a fully set control word
        ctrl_word = mk(8'd3, 1, 1, 1, 1, 1, 1);
        repeat (3) @(negedge clk);
        check("R11 cclk", int'(c0) + int'(c1), 0);
        check("R11 ticks", int'(r0) + int'(f0) + int'(r1) + int'(f1), 0);
        check("R11 flags", int'(n1) + int'(fl0) + int'(bw0), 0);
        ctrl_word = '0;
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R9: vector table walked once
        for (int i = 0; i < NVEC; i++) begin
            sel = VEC[i][32];
            tag = (VEC[i][31:24] == 8'd255) ? "R3" : (VEC[i][32] ? "R2" : "R1");
            ctrl_word = mk(VEC[i][31:24], 1, 0, 0, 0, 0, 0);
            wait_rise();
            wait_rise();
            measure(hi, lo, rt, ft);
            check({tag, " high"}, hi, int'(VEC[i][23:12]));
            check({tag, " low"}, lo, int'(VEC[i][11:0]));
            check("R9 rise count", rt, 1);
            check("R9 fall count", ft, 1);
        end

        // R8: change inside a running period
        sel = 1'b0;
        ctrl_word = mk(8'd9, 1, 0, 0, 0, 0, 0);
        wait_rise();
        wait_rise();
        ctrl_word = mk(8'd1, 1, 0, 0, 0, 0, 0);
        measure(hi, lo, rt, ft);
        check("R8 old high", hi, 10);
        check("R8 old low", lo, 10);
        measure(hi, lo, rt, ft);
        check("R8 new high", hi, 2);
        check("R8 new low", lo, 2);

        // R4: clear enable, clock held low with no strobes
        ctrl_word = mk(8'd2, 0, 0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        hi = 0;
        for (int k = 0; k < 20; k++) begin
            hi += int'(c0) + int'(r0) + int'(f0) + int'(c1) + int'(r1) + int'(f1);
            @(negedge clk);
        end
        check("R4 stopped", hi, 0);
        // R4: restart timing
        ctrl_word = mk(8'd2, 1, 0, 0, 0, 0, 0);
        @(negedge clk);
        check("R4 not yet", int'(c0), 0);
        @(negedge clk);
        check("R4 first rise", int'(c0) + int'(r0), 2);

        // R5: bypass follows master clock
        ctrl_word = mk(8'd5, 1, 1, 0, 0, 0, 0);
        @(posedge clk);
        #(CLK_PERIOD/4);
        check("R5 high half", int'(c0) + int'(c1), 2);
        check("R5 ticks", int'(r0) + int'(f0) + int'(r1) + int'(f1), 4);
        #(CLK_PERIOD/2);
        check("R5 low half", int'(c0) + int'(c1), 0);

        // R6: falling-edge launch flag
        @(negedge clk);
        ctrl_word = mk(8'd0, 1, 1, 1, 0, 0, 0);
        @(negedge clk);
        check("R6 alt bypass", int'(n1), 1);
        check("R6 std law", int'(n0), 0);
        ctrl_word = mk(8'd0, 1, 0, 1, 0, 0, 0);
        @(negedge clk);
        check("R6 no bypass", int'(n1), 0);

        // R7 R10: width decode and flow enable
        ctrl_word = mk(8'd0, 0, 0, 0, 1, 1, 0);
        @(negedge clk);
        check("R7 four", int'(bw0), 1);
        check("R10 flow on", int'(fl0) + int'(fl1), 2);
        ctrl_word = mk(8'd0, 0, 0, 0, 0, 0, 1);
        @(negedge clk);
        check("R7 eight", int'(bw1), 2);
        check("R10 flow off", int'(fl0), 0);
        ctrl_word = mk(8'd0, 0, 0, 0, 0, 1, 1);
        @(negedge clk);
        check("R7 both", int'(bw0), 2);
        ctrl_word = mk(8'd0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        check("R7 one", int'(bw0), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule